// File: doc/BRIEF.md
# Edge-Tracking Oversampled Serial Receiver

This block receives an asynchronous serial line that rests high between characters. The line is sampled on every cycle of a fast system clock, brought into the clock domain by a two-flop synchroniser and cleaned by a three-sample majority vote. A programmable divisor gives the length of one bit in clock cycles. For example, a 40 MHz clock needs a divisor near 16667 at 2400 baud, near 694 at 57.6 kbaud and near 43 at 921.6 kbaud.

Each character lasts ten bit-times. It begins with a low start bit, then carries one frame bit, then seven data bits with the least significant bit first, and ends with a high stop bit. The next character may start right after the stop bit with no rest time in between. The bit-timing counter is aligned on the falling edge of the start bit. It is aligned again on every level change of the filtered line inside the character, so that every sample stays near the middle of its bit. Because of this, a sender whose rate is off by several percent can still send long back-to-back bursts without the sampling point drifting into a neighbouring bit. The receiver reports each character with a one-cycle strobe, reports a bad stop bit with an error pulse, and shows an idle flag while it waits for a start bit.

Top module: `edge_track_rx`

## Requirements
- R1: After reset, `idle` is 1, `valid` and `frame_err` are 0, and `frame_bit` and `data_out` are 0.
- R2: Each character is received as: start (low), frame bit, `data_out[0]` through `data_out[6]`, stop (high). Each bit lasts `bit_div` cycles. A good character gives a one-cycle `valid` pulse, and at the same time `frame_bit` and `data_out` are loaded. These two outputs change at no other time.
- R3: A low pulse on `rx_line` that lasts one clock cycle is removed by the input filter. Afterwards `idle` stays 1 and no `valid` or `frame_err` pulse appears.
- R4: A falling edge whose filtered line is high again at the half-bit check (`bit_div/2` cycles after the edge) is rejected. The receiver goes back to idle with no `valid` and no `frame_err`.
- R5: Every filtered line edge that falls between the start check and the stop sample reloads the bit counter, so the next sample comes `bit_div/2` cycles later. As a result, characters sent with a bit period 12.5 % shorter or longer than `bit_div` are received correctly when no run of equal bits is longer than two. (A plain start-aligned receiver loses such characters.)
- R6: Characters sent back to back, with the next start bit right after a stop bit, are all received in order.
- R7: A low line at the stop-bit sample gives a one-cycle `frame_err` pulse and no `valid` pulse. The receiver then ignores the line until it has gone high, and after that it accepts the next character normally.
- R8: `bit_div` may be any value from 4 to 2^DIV_W-1. It is read each time the bit counter reloads.
- R9: `valid` and `frame_err` are never high in the same cycle, and neither one is high for two cycles in a row.
- R10: `idle` is 1 exactly while the receiver waits for a start bit. It is 0 while a character is being received and while the receiver waits for the line to go high after a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used as the oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial line, high when idle |
| bit_div | input | DIV_W | Bit period in clock cycles |
| frame_bit | output | 1 | Frame bit of the last good character |
| data_out | output | DATA_BITS | Data bits of the last good character |
| valid | output | 1 | One-cycle strobe for a good character |
| frame_err | output | 1 | One-cycle pulse for a bad stop bit |
| idle | output | 1 | High while waiting for a start bit |

## Verification
The bench keeps the default widths (16-bit divisor, seven data bits). It mostly runs with a divisor of 16, which makes a ten-bit character 160 cycles long. At that size the bench can send all 256 combinations of frame bit and data back to back in one burst. It can also send bursts whose bit period is off by two cycles in either direction, far enough that only the edge re-centring keeps the stop sample inside the stop bit. Divisors of 4 and 43 test the smallest allowed half-bit timing and the timing of the fastest rate on a 40 MHz clock.

// File: rtl/etr_pkg.sv
package etr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_BITS  = 3'd2,
    ST_STOP  = 3'd3,
    ST_HOLD  = 3'd4
  } etr_state_e;
endpackage

// File: rtl/etr_filter.sv
// Synchroniser, 3-sample majority vote and edge detect for the serial line.
module etr_filter #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic edge_o
);
  logic [SYNC_DEPTH-1:0] sync_q, sync_d;
  logic [2:0]            hist_q, hist_d;
  logic                  level_q, level_d;
  logic                  prev_q;

  always_comb begin
    sync_d  = {sync_q[SYNC_DEPTH-2:0], line_i};
    hist_d  = {hist_q[1:0], sync_q[SYNC_DEPTH-1]};
    level_d = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) |
              (hist_q[1] & hist_q[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync_q  <= sync_d;
      hist_q  <= hist_d;
      level_q <= level_d;
      prev_q  <= level_q;
    end
  end

  assign level_o = level_q;
  assign edge_o  = level_q ^ prev_q;
endmodule

// File: rtl/etr_timer.sv
// Down-counting bit timer; tick_o marks a sample point.
module etr_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             reload_half_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (reload_half_i)
      cnt_d = (div_i >> 1) - ONE;
    else if (cnt_q == '0)
      cnt_d = div_i - ONE;
    else
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/etr_fsm.sv
// Character framing: start check, bit collection, stop check, error hold.
module etr_fsm
  import etr_pkg::*;
#(
  parameter int DATA_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 level_i,
  input  logic                 edge_i,
  input  logic                 tick_i,
  output logic                 reload_o,
  output logic                 frame_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 err_o,
  output logic                 idle_o
);
  localparam int              NBITS = DATA_BITS + 1;
  localparam int              IDX_W = $clog2(NBITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBITS - 1);

  etr_state_e           state_q, state_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [NBITS-1:0]     shift_q, shift_d;
  logic                 frame_q, frame_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 valid_q, valid_d;
  logic                 err_q, err_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    shift_d  = shift_q;
    frame_d  = frame_q;
    data_d   = data_q;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    reload_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (edge_i && !level_i) begin
          reload_o = 1'b1;
          state_d  = ST_START;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (!level_i) begin
            state_d = ST_BITS;
            idx_d   = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_BITS: begin
        if (tick_i) begin
          shift_d = {level_i, shift_q[NBITS-1:1]};
          if (idx_q == LAST) state_d = ST_STOP;
          else               idx_d   = idx_q + IDX_W'(1);
        end else if (edge_i) begin
          reload_o = 1'b1;
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          if (level_i) begin
            valid_d = 1'b1;
            frame_d = shift_q[0];
            data_d  = shift_q[NBITS-1:1];
            state_d = ST_IDLE;
          end else begin
            err_d   = 1'b1;
            state_d = ST_HOLD;
          end
        end else if (edge_i) begin
          reload_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (level_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      frame_q <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      frame_q <= frame_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign frame_o = frame_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign idle_o  = (state_q == ST_IDLE);
endmodule

// File: rtl/edge_track_rx.sv
module edge_track_rx #(
  parameter int DIV_W      = 16,
  parameter int DATA_BITS  = 7,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic [DIV_W-1:0]     bit_div,
  output logic                 frame_bit,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 valid,
  output logic                 frame_err,
  output logic                 idle
);
  logic line_lvl;
  logic line_edge;
  logic sample_tick;
  logic recentre;

  etr_filter #(.SYNC_DEPTH(SYNC_DEPTH)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (rx_line),
    .level_o (line_lvl),
    .edge_o  (line_edge)
  );

  etr_timer #(.DIV_W(DIV_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .div_i         (bit_div),
    .reload_half_i (recentre),
    .tick_o        (sample_tick)
  );

  etr_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (line_lvl),
    .edge_i   (line_edge),
    .tick_i   (sample_tick),
    .reload_o (recentre),
    .frame_o  (frame_bit),
    .data_o   (data_out),
    .valid_o  (valid),
    .err_o    (frame_err),
    .idle_o   (idle)
  );
endmodule

// File: rtl/etr_rx_chk.sv
module etr_rx_chk #(
  parameter int DIV_W     = 16,
  parameter int DATA_BITS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DIV_W-1:0]     bit_div,
  input logic                 frame_bit,
  input logic [DATA_BITS-1:0] data_out,
  input logic                 valid,
  input logic                 frame_err,
  input logic                 idle
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && frame_err)); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R9
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R9
  AST_DATA_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(data_out) || !$stable(frame_bit)) |-> valid); // R2
  AST_VALID_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> idle); // R10
  AST_ERR_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !idle); // R7
  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (bit_div >= DIV_W'(4))); // R8
endmodule

bind edge_track_rx etr_rx_chk #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_div   (bit_div),
  .frame_bit (frame_bit),
  .data_out  (data_out),
  .valid     (valid),
  .frame_err (frame_err),
  .idle      (idle)
);

// File: tb/sim_edge_track_rx.sv
module sim_edge_track_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 16;
  localparam int DATA_BITS  = 7;

  logic                 clk;
  logic                 rst_n;
  logic                 rx_line;
  logic [DIV_W-1:0]     bit_div;
  logic                 frame_bit;
  logic [DATA_BITS-1:0] data_out;
  logic                 valid;
  logic                 frame_err;
  logic                 idle;

  edge_track_rx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_div(bit_div),
    .frame_bit(frame_bit), .data_out(data_out), .valid(valid),
    .frame_err(frame_err), .idle(idle)
  );

  int ntests;
  int nfail;
  int nrx;
  int nerr;
  int idle_low;
  int viol;
  bit done;
  bit prev_strobe;
  logic [7:0] rx_log [0:511];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        rx_log[nrx[8:0]] = {data_out, frame_bit};
        nrx = nrx + 1;
      end
      if (frame_err) nerr = nerr + 1;
      if (!idle) idle_low = idle_low + 1;
      if ((valid && frame_err) || (prev_strobe && (valid || frame_err))) viol = viol + 1;
      prev_strobe = valid || frame_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests = ntests + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_char(input logic frm, input logic [6:0] dat,
                           input int period, input logic stop_lvl);
    rx_line = 1'b0; wait_cyc(period);
    rx_line = frm;  wait_cyc(period);
    for (int b = 0; b < 7; b++) begin
      rx_line = dat[b]; wait_cyc(period);
    end
    rx_line = stop_lvl; wait_cyc(period);
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ntests = ntests + 1;
      nfail  = nfail + 1;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    int base;
    ntests = 0; nfail = 0; nrx = 0; nerr = 0; idle_low = 0; viol = 0;
    done = 1'b0; prev_strobe = 1'b0;
    rx_line = 1'b1;
    bit_div = DIV_W'(16);
    rst_n   = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1: reset state
    chk(idle == 1'b1, "R1 idle after reset", int'(idle), 1);
    chk(valid == 1'b0 && frame_err == 1'b0, "R1 strobes after reset",
        int'({valid, frame_err}), 0);
    chk(data_out == '0 && frame_bit == 1'b0, "R1 outputs after reset",
        int'({data_out, frame_bit}), 0);

    // R2 / R6: all 256 frame+data combinations, back to back, divisor 16
    base = nrx;
    for (int v = 0; v < 256; v++) send_char(v[0], v[7:1], 16, 1'b1);
    wait_cyc(40);
    chk(nrx - base == 256, "R6 back-to-back count", nrx - base, 256);
    for (int v = 0; v < 256; v++)
      chk(rx_log[(base + v) % 512] == 8'(v), "R2 frame/data sweep",
          int'(rx_log[(base + v) % 512]), v);
    chk(nerr == 0, "R2 no framing error in sweep", nerr, 0);

    // R8: smallest divisor
    bit_div = DIV_W'(4);
    base = nrx;
    for (int v = 0; v < 16; v++) send_char(v[0], 7'(v * 9), 4, 1'b1);
    wait_cyc(20);
    chk(nrx - base == 16, "R8 div=4 count", nrx - base, 16);
    for (int v = 0; v < 16; v++)
      chk(rx_log[(base + v) % 512] == {7'(v * 9), v[0]}, "R8 div=4 data",
          int'(rx_log[(base + v) % 512]), int'({7'(v * 9), v[0]}));

    // R8: divisor 43 (fast-rate timing)
    bit_div = DIV_W'(43);
    base = nrx;
    for (int v = 0; v < 4; v++) send_char(~v[0], 7'(v * 37 + 5), 43, 1'b1);
    wait_cyc(100);
    chk(nrx - base == 4, "R8 div=43 count", nrx - base, 4);
    for (int v = 0; v < 4; v++)
      chk(rx_log[(base + v) % 512] == {7'(v * 37 + 5), ~v[0]}, "R8 div=43 data",
          int'(rx_log[(base + v) % 512]), int'({7'(v * 37 + 5), ~v[0]}));

    // R5: sender bit period off by -2 and +2 cycles against divisor 16
    bit_div = DIV_W'(16);
    for (int p = 14; p <= 18; p += 4) begin
      base = nrx;
      for (int k = 0; k < 12; k++) begin
        if (k[0]) send_char(1'b0, 7'h33, p, 1'b1);
        else      send_char(1'b1, 7'h2A, p, 1'b1);
      end
      wait_cyc(60);
      chk(nrx - base == 12, "R5 drift burst count", nrx - base, 12);
      for (int k = 0; k < 12; k++)
        chk(rx_log[(base + k) % 512] == (k[0] ? 8'h66 : 8'h55), "R5 drift data",
            int'(rx_log[(base + k) % 512]), k[0] ? 8'h66 : 8'h55);
    end
    chk(nerr == 0, "R5 no framing error under drift", nerr, 0);

    // R3: single-cycle glitch is filtered away
    base = nrx; idle_low = 0;
    rx_line = 1'b0; wait_cyc(1);
    rx_line = 1'b1; wait_cyc(40);
    chk(idle_low == 0, "R3 idle held through glitch", idle_low, 0);
    chk(nrx == base && nerr == 0, "R3 no output from glitch", nrx - base + nerr, 0);

    // R4: low shorter than half a bit is rejected
    base = nrx; idle_low = 0;
    rx_line = 1'b0; wait_cyc(5);
    rx_line = 1'b1; wait_cyc(40);
    chk(idle_low > 0, "R4 start seen then aborted", idle_low, 1);
    chk(idle == 1'b1, "R4 back to idle", int'(idle), 1);
    chk(nrx == base && nerr == 0, "R4 no output from false start",
        nrx - base + nerr, 0);

    // R7 / R10: bad stop bit, line held low, then recovery
    base = nrx;
    send_char(1'b1, 7'h11, 16, 1'b0);
    wait_cyc(40);
    chk(nerr == 1, "R7 framing error pulse count", nerr, 1);
    chk(nrx == base, "R7 no valid on bad stop", nrx - base, 0);
    chk(idle == 1'b0, "R10 idle low while waiting for high line", int'(idle), 0);
    rx_line = 1'b1; wait_cyc(12);
    chk(idle == 1'b1, "R10 idle after line returns high", int'(idle), 1);
    send_char(1'b0, 7'h4C, 16, 1'b1);
    wait_cyc(30);
    chk(nrx == base + 1, "R7 char after recovery count", nrx - base, 1);
    chk(rx_log[base % 512] == {7'h4C, 1'b0}, "R7 char after recovery data",
        int'(rx_log[base % 512]), int'({7'h4C, 1'b0}));

    // R9: strobe exclusivity and width over the whole run
    chk(viol == 0, "R9 strobe width/exclusion", viol, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule